// File: doc/BRIEF.md
# Atomic Hardware Lock Memory

A bank of single-bit hardware locks for mutual exclusion among bus masters that share memory. Each lock is one 32-bit word in the address space, and masters use only plain reads and writes to reach it. A read is the acquire primitive. It returns the lock's previous state in bit 0 and leaves the lock held, all in one indivisible access. A write carries the new state in bit 0, so a zero releases the lock. Spin loops, counting semaphores and barriers can all be built in software from this single test-and-set word.

Several requesters share the bank. A fixed-priority arbiter lets exactly one access complete per clock cycle, so no two accesses ever interleave on the same lock. A requester raises its read or write strobe with an address and holds them until it sees `req_ready`. A read's data returns on the following cycle, marked by that requester's bit of `rsp_valid`. The bank size is a parameter; the address space covers up to 16K lock words. Word addresses above the bank read as zero and ignore writes.

Top module: `lock_bank`

## Requirements
- R1: After reset every lock is free, so the first read of any in-range lock returns 0.
- R2: A read returns the lock's state as it was before the access and leaves the lock held, so an immediate second read of the same lock returns 1.
- R3: Read data bits 31 down to 1 are always zero; the state bit is bit 0.
- R4: A write with bit 0 of the write data equal to 0 frees the lock. Writing 0 to a lock that is already free leaves it free.
- R5: A write with bit 0 equal to 1 holds the lock and produces no read response.
- R6: In each cycle at most one requester sees `req_ready`: the lowest-numbered requester that has a strobe raised. Any requester that is alone is granted in the same cycle. Requesters that are not granted wait.
- R7: When several requesters read the same free lock at once, exactly one of them reads 0.
- R8: The lock index is byte-address bits [AW-1:2]. Addresses that differ only in bits 1:0 select the same lock, and neighbouring words are independent.
- R9: An address whose index is at or above LOCKS reads as 0 and ignores writes, without aliasing onto any in-range lock.
- R10: One cycle after a read is granted, `rsp_valid` is one-hot at the reading requester's bit. Granted writes and idle cycles give `rsp_valid` = 0. A request with both strobes raised counts as a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rd | input | NREQ | Read (acquire) strobe per requester |
| req_wr | input | NREQ | Write strobe per requester |
| req_addr | input | NREQ*AW | Byte address per requester; requester i uses slice [i*AW +: AW] |
| req_wdata | input | NREQ*32 | Write data per requester; only bit 0 of each word is used |
| req_ready | output | NREQ | One-hot grant; the access completes at this clock edge |
| rsp_valid | output | NREQ | Read data valid, one cycle after the read's grant |
| rsp_data | output | 32 | Read data: previous lock state in bit 0, zeros above |

## Verification
The assertions check the following on every cycle:
- the grant is one-hot;
- the grant goes to the lowest-numbered active requester, and some requester is granted whenever any strobe is raised;
- a response follows exactly the granted reads;
- the upper read-data bits stay zero.

Lock contents cannot be checked from the ports in a single cycle. These need the bench's scenarios, which are compared against a reference model:
- the destructive read;
- release and set by writes;
- the byte offset being ignored;
- the out-of-range behaviour without aliasing;
- exactly one winner when several requesters contend for one lock.

// File: rtl/lock_bank_pkg.sv
package lock_bank_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        LK_IDLE    = 2'd0,
        LK_ACQUIRE = 2'd1,
        LK_STORE   = 2'd2
    } lk_op_e;
endpackage

// File: rtl/lock_prio_arb.sv
module lock_prio_arb #(
    parameter int NREQ = 4
) (
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] grant
);
    logic [NREQ-1:0] grant_d;

    always_comb begin
        grant_d = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant_d    = '0;
                grant_d[i] = 1'b1;
            end
        end
    end

    assign grant = grant_d;
endmodule

// File: rtl/lock_addr_decode.sv
module lock_addr_decode #(
    parameter int AW     = 16,
    parameter int LOCKS  = 4096,
    parameter int LIDX_W = 12
) (
    input  logic [AW-1:0]     addr,
    output logic [LIDX_W-1:0] idx,
    output logic              in_range
);
    localparam int FULL_W = AW - 2;
    localparam logic [FULL_W:0] LIMIT = (FULL_W + 1)'(LOCKS);

    logic [FULL_W-1:0] word_idx;
    logic              unused_byte_ofs;

    assign word_idx        = addr[AW-1:2];
    assign unused_byte_ofs = ^addr[1:0];

    generate
        if (LIDX_W < FULL_W) begin : g_trunc
            logic unused_idx_hi;
            assign unused_idx_hi = ^word_idx[FULL_W-1:LIDX_W];
            assign idx           = word_idx[LIDX_W-1:0];
        end else begin : g_pad
            assign idx = LIDX_W'(word_idx);
        end
    endgenerate

    assign in_range = ({1'b0, word_idx} < LIMIT);
endmodule

// File: rtl/lock_store.sv
module lock_store
    import lock_bank_pkg::*;
#(
    parameter int LOCKS  = 4096,
    parameter int LIDX_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lk_op_e            op,
    input  logic [LIDX_W-1:0] idx,
    input  logic              in_range,
    input  logic              wbit,
    output logic              old_bit
);
    logic [LOCKS-1:0] locks_d, locks_q;

    always_comb begin
        locks_d = locks_q;
        old_bit = 1'b0;
        if (in_range) begin
            old_bit = locks_q[idx];
            unique case (op)
                LK_ACQUIRE: locks_d[idx] = 1'b1;
                LK_STORE:   locks_d[idx] = wbit;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) locks_q <= '0;
        else        locks_q <= locks_d;
    end
endmodule

// File: rtl/lock_bank.sv
module lock_bank
    import lock_bank_pkg::*;
#(
    parameter int NREQ  = 4,
    parameter int AW    = 16,
    parameter int LOCKS = 4096
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREQ-1:0]        req_rd,
    input  logic [NREQ-1:0]        req_wr,
    input  logic [NREQ*AW-1:0]     req_addr,
    input  logic [NREQ*DATA_W-1:0] req_wdata,
    output logic [NREQ-1:0]        req_ready,
    output logic [NREQ-1:0]        rsp_valid,
    output logic [DATA_W-1:0]      rsp_data
);
    localparam int LIDX_W = (LOCKS > 1) ? $clog2(LOCKS) : 1;

    typedef struct packed {
        logic [NREQ-1:0] valid;
        logic            state;
    } rsp_t;

    logic [NREQ-1:0]   grant;
    logic [AW-1:0]     sel_addr;
    logic              sel_rd;
    logic              sel_wbit;
    lk_op_e            sel_op;
    logic [LIDX_W-1:0] lk_idx;
    logic              lk_in_range;
    logic              lk_old;
    logic              unused_wdata_hi;
    rsp_t              rsp_d, rsp_q;

    lock_prio_arb #(.NREQ(NREQ)) u_arb (
        .req   (req_rd | req_wr),
        .grant (grant)
    );

    always_comb begin
        sel_addr        = '0;
        sel_rd          = 1'b0;
        sel_wbit        = 1'b0;
        unused_wdata_hi = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            unused_wdata_hi = unused_wdata_hi ^ (^req_wdata[i*DATA_W+1 +: DATA_W-1]);
            if (grant[i]) begin
                sel_addr = req_addr[i*AW +: AW];
                sel_rd   = req_rd[i];
                sel_wbit = req_wdata[i*DATA_W];
            end
        end
        if (!(|grant))   sel_op = LK_IDLE;
        else if (sel_rd) sel_op = LK_ACQUIRE;
        else             sel_op = LK_STORE;
    end

    lock_addr_decode #(.AW(AW), .LOCKS(LOCKS), .LIDX_W(LIDX_W)) u_dec (
        .addr     (sel_addr),
        .idx      (lk_idx),
        .in_range (lk_in_range)
    );

    lock_store #(.LOCKS(LOCKS), .LIDX_W(LIDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (sel_op),
        .idx      (lk_idx),
        .in_range (lk_in_range),
        .wbit     (sel_wbit),
        .old_bit  (lk_old)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = grant & req_rd;
        rsp_d.state = (sel_op == LK_ACQUIRE) ? lk_old : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign req_ready = grant;
    assign rsp_valid = rsp_q.valid;
    assign rsp_data  = {{(DATA_W-1){1'b0}}, rsp_q.state};
endmodule

// File: rtl/lock_bank_chk.sv
module lock_bank_chk #(
    parameter int NREQ   = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NREQ-1:0]   req_rd,
    input logic [NREQ-1:0]   req_wr,
    input logic [NREQ-1:0]   req_ready,
    input logic [NREQ-1:0]   rsp_valid,
    input logic [DATA_W-1:0] rsp_data
);
    // R6: at most one grant per cycle
    p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    // R6: some requester is granted whenever any strobe is raised
    p_no_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_rd | req_wr)) |-> (|req_ready));

    generate
        for (genvar i = 0; i < NREQ; i++) begin : g_prio
            localparam logic [NREQ-1:0] LOWER = NREQ'((1 << i) - 1);
            // R6: grant only to an active requester with no active lower index
            p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
                req_ready[i] |-> ((req_rd[i] | req_wr[i]) && (((req_rd | req_wr) & LOWER) == '0)));
        end
    endgenerate

    // R10: a granted read gives its response on the next cycle
    p_rsp_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_ready & req_rd)) |=> (rsp_valid == $past(req_ready & req_rd)));

    // R10: no response without a granted read
    p_rsp_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(req_ready & req_rd)) |=> (rsp_valid == '0));

    // R3: upper read-data bits stay zero
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_data[DATA_W-1:1] == '0);
endmodule

bind lock_bank lock_bank_chk #(.NREQ(NREQ), .DATA_W(32)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_rd    (req_rd),
    .req_wr    (req_wr),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/lock_bank_test.sv
module lock_bank_test;
    localparam int NREQ  = 4;
    localparam int AW    = 16;
    localparam int LOCKS = 4096;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NREQ-1:0]     req_rd = '0;
    logic [NREQ-1:0]     req_wr = '0;
    logic [NREQ*AW-1:0]  req_addr = '0;
    logic [NREQ*32-1:0]  req_wdata = '0;
    logic [NREQ-1:0]     req_ready;
    logic [NREQ-1:0]     rsp_valid;
    logic [31:0]         rsp_data;

    int total = 0;
    int fails = 0;
    bit ref_l [LOCKS];

    always #10 clk = ~clk;

    lock_bank #(.NREQ(NREQ), .AW(AW), .LOCKS(LOCKS)) uut (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic bit in_bank(input logic [AW-1:0] a);
        return (int'(a >> 2) < LOCKS);
    endfunction

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        return in_bank(a) ? {31'b0, ref_l[a >> 2]} : 32'd0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one access by one requester; returns after the response cycle
    task automatic single(input int r, input bit rd, input logic [AW-1:0] a, input bit wb, input string req);
        logic [31:0]     expd;
        logic [NREQ-1:0] expv;
        expd = exp_read(a);
        expv = rd ? NREQ'(1 << r) : '0;
        @(negedge clk);
        req_rd[r]              = rd;
        req_wr[r]              = !rd;
        req_addr[r*AW +: AW]   = a;
        req_wdata[r*32 +: 32]  = {$urandom() & 32'hFFFF_FFFE} | {31'b0, wb};
        #1;
        chk(req_ready == NREQ'(1 << r), "R6 lone grant", {28'b0, req_ready}, 32'(1 << r));
        @(negedge clk);
        req_rd[r] = 1'b0;
        req_wr[r] = 1'b0;
        chk(rsp_valid == expv, {req, " R10 rsp_valid"}, {28'b0, rsp_valid}, {28'b0, expv});
        if (rd) chk(rsp_data == expd, {req, " R3 data"}, rsp_data, expd);
        if (in_bank(a)) ref_l[a >> 2] = rd ? 1'b1 : wb;
    endtask

    // all requesters in mask read lock a at once
    task automatic contend(input logic [NREQ-1:0] mask, input logic [AW-1:0] a);
        logic [NREQ-1:0] pend;
        logic [NREQ-1:0] lo;
        int              zeros;
        bit              was;
        pend  = mask;
        zeros = 0;
        was   = ref_l[a >> 2];
        @(negedge clk);
        for (int i = 0; i < NREQ; i++) begin
            if (mask[i]) begin
                req_rd[i]            = 1'b1;
                req_addr[i*AW +: AW] = a;
            end
        end
        while (pend != '0) begin
            #1;
            lo = pend & (~pend + 1'b1);
            chk(req_ready == lo, "R6 priority", {28'b0, req_ready}, {28'b0, lo});
            @(negedge clk);
            chk(rsp_valid == lo, "R10 contention rsp", {28'b0, rsp_valid}, {28'b0, lo});
            if (rsp_data == 32'd0) zeros++;
            req_rd = req_rd & ~lo;
            pend   = pend & ~lo;
        end
        chk(zeros == (was ? 0 : 1), "R7 single winner", 32'(zeros), was ? 32'd0 : 32'd1);
        ref_l[a >> 2] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL R6 watchdog: actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        for (int i = 0; i < LOCKS; i++) ref_l[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == '0, "R10 reset rsp_valid", {28'b0, rsp_valid}, 32'd0);
        chk(req_ready == '0, "R6 reset ready", {28'b0, req_ready}, 32'd0);
        rst_n = 1'b1;

        // R1 reset state, R2 destructive read
        single(0, 1, 16'd0, 0, "R1 lock0");
        single(1, 1, 16'(5*4), 0, "R1 lock5");
        single(2, 1, 16'((LOCKS-1)*4), 0, "R1 last lock");
        single(3, 1, 16'(5*4), 0, "R2 reread");
        // R4 release, release of a free lock
        single(0, 0, 16'(5*4), 0, "R4 release");
        single(1, 1, 16'(5*4), 0, "R4 after release");
        single(2, 0, 16'(9*4), 0, "R4 free write");
        single(2, 0, 16'(9*4), 0, "R4 free write again");
        single(3, 1, 16'(9*4), 0, "R4 still free");
        // R5 write-one sets
        single(1, 0, 16'(7*4), 1, "R5 set");
        single(0, 1, 16'(7*4), 0, "R5 read set");
        // R8 byte offset ignored, neighbours independent
        single(2, 1, 16'(10*4+3), 0, "R8 offset3");
        single(3, 1, 16'(10*4+1), 0, "R8 offset1");
        single(0, 1, 16'(11*4+2), 0, "R8 neighbour");
        // R9 out of range, no aliasing onto low indices
        single(1, 0, 16'((LOCKS+100)*4), 1, "R9 oob write");
        single(2, 1, 16'((LOCKS+100)*4), 0, "R9 oob read");
        single(3, 1, 16'((LOCKS+100)*4), 0, "R9 oob reread");
        single(0, 1, 16'(100*4), 0, "R9 alias check");
        // R7 contention on a free lock and on a held lock
        contend(4'b1111, 16'(200*4));
        contend(4'b1010, 16'(200*4));
        single(0, 0, 16'(200*4), 0, "R4 release contended");
        contend(4'b0110, 16'(200*4+2));

        // random mix against the model
        for (int n = 0; n < 400; n++) begin
            int          r;
            int          k;
            logic [AW-1:0] a;
            r = int'($urandom() % NREQ);
            k = int'($urandom() % 3);
            if (($urandom() % 8) == 0) a = 16'((LOCKS + int'($urandom() % 8)) * 4);
            else                       a = 16'(300*4 + int'($urandom() % 8) * 4);
            a[1:0] = 2'($urandom());
            single(r, k == 0, a, k == 2, "R2 random");
        end
        for (int n = 0; n < 20; n++) begin
            logic [NREQ-1:0] m;
            m = NREQ'($urandom());
            if (m == '0) m = 4'b0011;
            if ($urandom() % 2) single(0, 0, 16'(400*4), 0, "R4 random release");
            contend(m, 16'(400*4));
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule